// File: doc/BRIEF.md
# Debug Development Control Register File

This block is a small word-wide register file that sits behind a debug scan interface. A debug host reads and writes 28 development registers through an address, write data, a write strobe and a read strobe. Read data comes back registered, and an invalid-address flag marks any access outside the implemented range. Most registers only store what is written so the host can read it back.

One register, at address 4, controls the processor directly. Its bit 0 drives a stall request to the core. Its bit 1 holds the core in reset. While bit 1 is set, the block reports an in-reset status, and other debug logic uses that status to suppress breakpoint evaluation. When a write takes bit 1 from one to zero, the block emits a single-cycle system reset request. A separate exception path can set or clear the stall bit without a host write, so the core can be frozen on a trapped exception.

Top module: `dbg_devctl_regfile`

## Requirements
- R1: A write to a valid address other than 4 (0 to 27) stores the full word, and a later read of that address returns it.
- R2: An access with address 28 or higher sets `dbg_err` to 1 in the next cycle and changes no register. A read of such an address returns zero. `dbg_err` is 0 after every cycle that has no such access.
- R3: Read data is registered and valid in the cycle after `dbg_rd`, holding until the next read. A read changes no register, output or status.
- R4: After any write to address 4, `cpu_stall_o` equals bit 0 of the written word from the next cycle on.
- R5: `cpu_in_reset_o` equals bit 1 of the control word at address 4.
- R6: `sys_reset_pulse_o` is 1 for exactly one cycle, in the cycle after a write to address 4 that changes bit 1 from 1 to 0. Writes that leave bit 1 at 0 or at 1 give no pulse.
- R7: In a cycle without a write to address 4, `exc_stall_set` sets control bit 0 and `exc_stall_clr` clears it. Set wins over clear, and a host write to address 4 wins over both. The other control bits are untouched.
- R8: A synchronous active-low reset clears all 28 registers, the stall output, the in-reset status, the reset pulse, the error flag and the read data.
- R9: A read and a write to the same address in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_addr | input | 8 | Register address |
| dbg_wdata | input | 32 | Write data |
| dbg_wr | input | 1 | Write strobe, one access per cycle |
| dbg_rd | input | 1 | Read strobe |
| exc_stall_set | input | 1 | Exception path request to set the stall bit |
| exc_stall_clr | input | 1 | Exception path request to clear the stall bit |
| dbg_rdata | output | 32 | Registered read data |
| dbg_err | output | 1 | Invalid-address flag for the previous cycle's access |
| cpu_stall_o | output | 1 | Processor stall request |
| cpu_in_reset_o | output | 1 | Processor held-in-reset status |
| sys_reset_pulse_o | output | 1 | One-cycle system reset request |

## Verification
A directed pass writes and reads back every address. It then probes out-of-range addresses at the edge (28), mid-range and all-ones, which separates the range check from a check of bits alone. Control-word writes are run in the sequences 0→1, 1→1, 1→0 and 0→0 on bit 1, which tells a true falling-edge detector apart from a level or any-write detector. The exception requests are tried alone, both at once, and together with a host write, which fixes their priority. A seeded random mix of reads, writes, invalid accesses and exception requests is then compared cycle by cycle against a bench model.

// File: rtl/dbgc_pkg.sv
// Package: shared constants of the debug development control register file.
// Assumes: the control word sits at a fixed address inside the register range.
package dbgc_pkg;
    localparam int DBGC_DATA_W    = 32;
    localparam int DBGC_ADDR_W    = 8;
    localparam int DBGC_NUM_REGS  = 28;
    localparam int DBGC_CTRL_ADDR = 4;
    localparam int DBGC_STALL_BIT = 0;
    localparam int DBGC_HOLD_BIT  = 1;
endpackage

// File: rtl/dbgc_decode.sv
// Module: address decoder.
// What it does: checks the range, picks the control slot and makes one-hot
// write selects for the plain storage words.
// Assumes: ADDR_W is at least as wide as the index of the last register.
module dbgc_decode #(
    parameter int ADDR_W    = dbgc_pkg::DBGC_ADDR_W,
    parameter int NUM_REGS  = dbgc_pkg::DBGC_NUM_REGS,
    parameter int CTRL_ADDR = dbgc_pkg::DBGC_CTRL_ADDR,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    output logic                in_range,
    output logic                hits_ctrl,
    output logic [IDX_W-1:0]    idx,
    output logic [NUM_REGS-1:0] wr_sel
);
    // Range check and index extraction
    always_comb begin
        in_range  = (addr < ADDR_W'(NUM_REGS));
        idx       = addr[IDX_W-1:0];
        hits_ctrl = in_range && (idx == IDX_W'(CTRL_ADDR));
    end

    // One-hot write enables for storage words; the control slot is never selected
    always_comb begin
        wr_sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr && in_range && !hits_ctrl && (idx == IDX_W'(i)))
                wr_sel[i] = 1'b1;
        end
    end
endmodule

// File: rtl/dbgc_word_store.sv
// Module: plain storage words.
// What it does: keeps one word per address, written on its select and cleared
// on reset; the control slot is a constant zero (the control word lives elsewhere).
// Assumes: at most one select is active per cycle.
module dbgc_word_store #(
    parameter int DATA_W    = dbgc_pkg::DBGC_DATA_W,
    parameter int NUM_REGS  = dbgc_pkg::DBGC_NUM_REGS,
    parameter int CTRL_ADDR = dbgc_pkg::DBGC_CTRL_ADDR,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] wr_sel,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DATA_W-1:0]   rd_word
);
    logic [DATA_W-1:0] words [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        if (g == CTRL_ADDR) begin : g_hole
            assign words[g] = '0;
        end else begin : g_reg
            // Store the host word when this slot is selected
            always_ff @(posedge clk) begin
                if (!rst_n)
                    words[g] <= '0;
                else if (wr_sel[g])
                    words[g] <= wdata;
            end

            // R2 / R1: a word not selected keeps its value
            assert_hold_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_sel[g] |=> $stable(words[g]));
        end
    end

    // Read multiplexer over the stored words
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i))
                rd_word = words[i];
        end
    end
endmodule

// File: rtl/dbgc_proc_ctrl.sv
// Module: processor control word.
// What it does: holds the control word, drives stall and in-reset from it,
// lets the exception path move the stall bit and detects the release of the
// hold bit to issue a one-cycle system reset request.
// Assumes: host write beats exception set, which beats exception clear.
module dbgc_proc_ctrl #(
    parameter int DATA_W    = dbgc_pkg::DBGC_DATA_W,
    parameter int STALL_BIT = dbgc_pkg::DBGC_STALL_BIT,
    parameter int HOLD_BIT  = dbgc_pkg::DBGC_HOLD_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              exc_set,
    input  logic              exc_clr,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              stall,
    output logic              in_reset,
    output logic              reset_pulse
);
    logic [DATA_W-1:0] ctrl_q;
    logic              pulse_q;

    // Update the control word from the host or the exception path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata;
        end else if (exc_set) begin
            ctrl_q[STALL_BIT] <= 1'b1;
        end else if (exc_clr) begin
            ctrl_q[STALL_BIT] <= 1'b0;
        end
    end

    // Flag a release of the hold bit for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= wr_ctrl && ctrl_q[HOLD_BIT] && !wdata[HOLD_BIT];
    end

    assign ctrl_word   = ctrl_q;
    assign stall       = ctrl_q[STALL_BIT];
    assign in_reset    = ctrl_q[HOLD_BIT];
    assign reset_pulse = pulse_q;

    // R4: stall follows bit 0 of a control write
    assert_stall_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (stall == $past(wdata[STALL_BIT])));

    // R6: a pulse only after a write that released the hold bit
    assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> ($past(wr_ctrl) && $past(in_reset) && !in_reset));

    // R6: the pulse is one cycle wide
    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !reset_pulse);

    // R7: an exception set without a host write stalls the core
    assert_exc_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_set && !wr_ctrl) |=> stall);

    // R7: an exception request leaves the hold bit alone
    assert_exc_keeps_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(in_reset));
endmodule

// File: rtl/dbg_devctl_regfile.sv
// Module: debug development control register file (top).
// What it does: decodes host accesses, stores plain words, holds the processor
// control word and returns registered read data and an invalid-address flag.
// Assumes: one access per cycle; a read and write together read the old value.
module dbg_devctl_regfile #(
    parameter int DATA_W    = dbgc_pkg::DBGC_DATA_W,
    parameter int ADDR_W    = dbgc_pkg::DBGC_ADDR_W,
    parameter int NUM_REGS  = dbgc_pkg::DBGC_NUM_REGS,
    parameter int CTRL_ADDR = dbgc_pkg::DBGC_CTRL_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [DATA_W-1:0] dbg_wdata,
    input  logic              dbg_wr,
    input  logic              dbg_rd,
    input  logic              exc_stall_set,
    input  logic              exc_stall_clr,
    output logic [DATA_W-1:0] dbg_rdata,
    output logic              dbg_err,
    output logic              cpu_stall_o,
    output logic              cpu_in_reset_o,
    output logic              sys_reset_pulse_o
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic                in_range;
    logic                hits_ctrl;
    logic [IDX_W-1:0]    idx;
    logic [NUM_REGS-1:0] wr_sel;
    logic [DATA_W-1:0]   store_word;
    logic [DATA_W-1:0]   ctrl_word;
    logic [DATA_W-1:0]   rdata_q;
    logic                err_q;

    dbgc_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .CTRL_ADDR(CTRL_ADDR)) u_decode (
        .addr     (dbg_addr),
        .wr       (dbg_wr),
        .in_range (in_range),
        .hits_ctrl(hits_ctrl),
        .idx      (idx),
        .wr_sel   (wr_sel)
    );

    dbgc_word_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .CTRL_ADDR(CTRL_ADDR)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_sel),
        .wdata  (dbg_wdata),
        .rd_idx (idx),
        .rd_word(store_word)
    );

    dbgc_proc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (dbg_wr && hits_ctrl),
        .wdata      (dbg_wdata),
        .exc_set    (exc_stall_set),
        .exc_clr    (exc_stall_clr),
        .ctrl_word  (ctrl_word),
        .stall      (cpu_stall_o),
        .in_reset   (cpu_in_reset_o),
        .reset_pulse(sys_reset_pulse_o)
    );

    // Capture read data on a read strobe; out-of-range reads give zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (dbg_rd)
            rdata_q <= !in_range ? '0 : (hits_ctrl ? ctrl_word : store_word);
    end

    // Flag any access that falls outside the register range
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= (dbg_wr || dbg_rd) && !in_range;
    end

    assign dbg_rdata = rdata_q;
    assign dbg_err   = err_q;

    // R2: the error flag only follows an out-of-range access
    assert_err_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_err |-> ($past(dbg_wr || dbg_rd) && ($past(dbg_addr) >= ADDR_W'(NUM_REGS))));

    // R3: read data moves only after a read strobe
    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_rd |=> $stable(dbg_rdata));
endmodule

// File: tb/dbg_devctl_regfile_tb_top.sv
`timescale 1ns/1ps
module dbg_devctl_regfile_tb_top;
    localparam int NREG = 28;
    localparam int CTRL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic        dbg_wr = 1'b0;
    logic        dbg_rd = 1'b0;
    logic        exc_stall_set = 1'b0;
    logic        exc_stall_clr = 1'b0;
    logic [31:0] dbg_rdata;
    logic        dbg_err;
    logic        cpu_stall_o;
    logic        cpu_in_reset_o;
    logic        sys_reset_pulse_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model [NREG];

    always #2.5 clk = ~clk;

    dbg_devctl_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_wr(dbg_wr), .dbg_rd(dbg_rd), .exc_stall_set(exc_stall_set),
        .exc_stall_clr(exc_stall_clr), .dbg_rdata(dbg_rdata), .dbg_err(dbg_err),
        .cpu_stall_o(cpu_stall_o), .cpu_in_reset_o(cpu_in_reset_o),
        .sys_reset_pulse_o(sys_reset_pulse_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit addr_ok(input logic [7:0] a);
        return a < 8'(NREG);
    endfunction

    function automatic bit pulse_exp(input bit wr, input logic [7:0] a, input logic [31:0] d);
        return wr && (a == 8'(CTRL)) && model[CTRL][1] && !d[1];
    endfunction

    // One access cycle: drive, let one edge pass, update model, check outputs
    task automatic op(input string req, input bit wr, input bit rd, input logic [7:0] a,
                      input logic [31:0] d, input bit es, input bit ec);
        logic [31:0] exp_rd;
        bit          exp_err;
        bit          exp_pulse;
        @(negedge clk);
        dbg_wr = wr; dbg_rd = rd; dbg_addr = a; dbg_wdata = d;
        exc_stall_set = es; exc_stall_clr = ec;
        exp_rd    = addr_ok(a) ? model[a[4:0]] : 32'h0;
        exp_err   = (wr || rd) && !addr_ok(a);
        exp_pulse = pulse_exp(wr, a, d);
        if (wr && a == 8'(CTRL)) model[CTRL] = d;
        else begin
            if (wr && addr_ok(a)) model[a[4:0]] = d;
            if (es) model[CTRL][0] = 1'b1;
            else if (ec) model[CTRL][0] = 1'b0;
        end
        @(negedge clk);
        dbg_wr = 1'b0; dbg_rd = 1'b0; exc_stall_set = 1'b0; exc_stall_clr = 1'b0;
        if (rd) check({req, " rdata (R3)"}, dbg_rdata, exp_rd);
        check({req, " err (R2)"}, 32'(dbg_err), 32'(exp_err));
        check({req, " stall (R4/R7)"}, 32'(cpu_stall_o), 32'(model[CTRL][0]));
        check({req, " in_reset (R5)"}, 32'(cpu_in_reset_o), 32'(model[CTRL][1]));
        check({req, " pulse (R6)"}, 32'(sys_reset_pulse_o), 32'(exp_pulse));
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NREG; i++) model[i] = '0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        apply_reset();
        // R8: state after reset
        check("R8 stall", 32'(cpu_stall_o), 0);
        check("R8 in_reset", 32'(cpu_in_reset_o), 0);
        check("R8 pulse", 32'(sys_reset_pulse_o), 0);
        check("R8 err", 32'(dbg_err), 0);
        check("R8 rdata", dbg_rdata, 0);

        // R1: write and read back every valid address (control word kept harmless)
        for (int i = 0; i < NREG; i++)
            op("R1 write", 1, 0, 8'(i), (i == CTRL) ? 32'hF0F0_0000 : (32'h5A00_0000 | 32'(i * 977)), 0, 0);
        for (int i = 0; i < NREG; i++) op("R1 readback", 0, 1, 8'(i), 0, 0, 0);

        // R2: out-of-range writes and reads change nothing and flag an error
        op("R2 write 28", 1, 0, 8'd28, 32'hDEAD_BEEF, 0, 0);
        op("R2 write 200", 1, 0, 8'd200, 32'h1234_5678, 0, 0);
        op("R2 write 255", 1, 0, 8'd255, 32'hFFFF_FFFF, 0, 0);
        op("R2 read 28", 0, 1, 8'd28, 0, 0, 0);
        op("R2 no error after", 0, 0, 8'd3, 0, 0, 0);
        for (int i = 0; i < NREG; i++) op("R2 unchanged", 0, 1, 8'(i), 0, 0, 0);

        // R4/R5/R6: control word sequences on the hold bit
        op("R4 stall on", 1, 0, 8'(CTRL), 32'h1, 0, 0);
        op("R5 hold on", 1, 0, 8'(CTRL), 32'h2, 0, 0);
        op("R6 hold kept", 1, 0, 8'(CTRL), 32'h3, 0, 0);
        op("R6 release", 1, 0, 8'(CTRL), 32'h1, 0, 0);
        op("R6 pulse one cycle", 0, 0, 8'd0, 0, 0, 0);
        op("R6 zero to zero", 1, 0, 8'(CTRL), 32'h0, 0, 0);

        // R3: reads leave control state alone
        op("R5 hold again", 1, 0, 8'(CTRL), 32'h2, 0, 0);
        op("R3 read ctrl", 0, 1, 8'(CTRL), 0, 0, 0);
        op("R3 read ctrl again", 0, 1, 8'(CTRL), 0, 0, 0);
        op("R6 release again", 1, 0, 8'(CTRL), 32'h0, 0, 0);

        // R7: exception path priorities
        op("R7 set", 0, 0, 8'd0, 0, 1, 0);
        op("R7 read", 0, 1, 8'(CTRL), 0, 0, 0);
        op("R7 clear", 0, 0, 8'd0, 0, 0, 1);
        op("R7 both", 0, 0, 8'd0, 0, 1, 1);
        op("R7 host wins", 1, 0, 8'(CTRL), 32'h0, 1, 0);
        op("R7 set with other write", 1, 0, 8'd9, 32'h0BAD_F00D, 1, 0);
        op("R7 read other", 0, 1, 8'd9, 0, 0, 0);

        // R9: read and write together return the old value
        op("R9 rd+wr", 1, 1, 8'd7, 32'hCAFE_0007, 0, 0);
        op("R9 new value", 0, 1, 8'd7, 0, 0, 0);

        // Random mix against the model
        for (int n = 0; n < 600; n++) begin
            int kind = $urandom_range(0, 9);
            logic [7:0]  a = (kind < 3) ? 8'(CTRL) : 8'($urandom_range(0, 34));
            logic [31:0] d = $urandom;
            op("R1 random", kind != 9 && $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
               a, d, $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0);
        end

        // R8: reset clears every register
        apply_reset();
        check("R8 stall after second reset", 32'(cpu_stall_o), 0);
        for (int i = 0; i < NREG; i++) op("R8 cleared", 0, 1, 8'(i), 0, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule